// File: doc/BRIEF.md
# Bus Error and Halt Exception Decoder

This block sits between a processor's bus-cycle sequencer and two active-low exception pins: bus error and halt. Each pin passes through its own synchronizer. The block reads the pin pair only on the clock edge where the sequencer reports that a bus cycle has terminated. It classifies each terminated cycle as one of four results:

- a normal completion,
- a bus error exception,
- a request to retry the cycle,
- a suspension of external bus activity.

Each result is a one-clock pulse.

After a bus error, and after reset, the block holds an exception-processing window open. The window stays open until the processor reports that it has finished stacking and fetching for that exception. A lone bus error that arrives inside the window is a double bus fault. On a double bus fault the block halts the processor and pulls the open-drain halt line low until the next reset. Single-stepping uses halt in the same way: halt is asserted, one cycle is let through, and halt is asserted again before that cycle ends.

The block has four named states:

- `ST_RUN`: bus cycles run.
- `ST_RETRY_WAIT`: the block waits for both pins to be released before the retried cycle.
- `ST_SUSPEND`: bus activity is held until halt is released.
- `ST_HALTED`: double bus fault; the only way out is reset.

Its transitions are:

- run→retry_wait (retry decoded)
- run→suspend (halt alone)
- run→halted (double fault)
- retry_wait→run (both pins released)
- suspend→run (halt released)
- halted→(reset only)

Top module: `bus_exc_decoder`

## Requirements
- R1: After reset all four result pulses are low, `hold_o` is 0, `halted_o` is 0 and `halt_drive_o` is 0, and the exception-processing window is open.
- R2: A terminated cycle with neither pin asserted gives `res_done_o` high for exactly the one clock after the termination edge.
- R3: A terminated cycle with bus error low and halt high, outside the exception window, gives a one-clock `res_error_o` and opens the exception window.
- R4: A terminated cycle with both pins low gives a one-clock `res_retry_o`; `hold_o` then stays 1 until both synchronized pins read high, and it drops on the following edge.
- R5: A terminated cycle with halt low and bus error high gives a one-clock `res_suspend_o`; `hold_o` stays 1 until the synchronized halt reads high.
- R6: A lone bus error at termination while the exception window is open gives no result pulse. Instead it sets `halted_o`, `hold_o` and `halt_drive_o` (drive the halt line low). This also holds for the window that reset opens.
- R7: Once halted, the block stays halted and keeps driving halt until reset, and later terminations produce no result pulses.
- R8: The result pulses are one-hot or all zero, and they appear only in the clock after `term_i` was high. Pin activity without `term_i` has no effect.
- R9: Each pin passes through `SYNC_STAGES` (default 2) flip-flops. A pin change reaches the decoder only after that many rising edges, so a change one edge before termination is not seen.
- R10: An `exc_done_i` pulse closes the exception window, so the next lone bus error is again an ordinary bus error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| term_i | input | 1 | Bus cycle terminates on this edge |
| berr_n_i | input | 1 | Bus error pin, active low |
| halt_n_i | input | 1 | Halt pin as seen on the wire, active low |
| exc_done_i | input | 1 | Exception stacking and vector fetch finished |
| res_done_o | output | 1 | Normal completion pulse |
| res_error_o | output | 1 | Bus error exception pulse |
| res_retry_o | output | 1 | Retry request pulse |
| res_suspend_o | output | 1 | Bus suspend pulse |
| hold_o | output | 1 | Do not start a new bus cycle |
| halted_o | output | 1 | Processor halted by double bus fault |
| halt_drive_o | output | 1 | Pull the open-drain halt line low |

## Verification
The bench checks the following corner cases, each against the failure it would show in a wrong design:

- **Joint pin decode.** A decoder that read the pins separately would report a bus error where a retry is asked for.
- **Release wait after retry and suspend.** A design that skipped the wait would let a bus cycle start while a pin is still held.
- **Double fault from both windows.** The bench raises a double fault from the window that reset opens and from the window that a bus error opens. A design that tracked only one of them would take an ordinary error and never halt.
- **Window closed by `exc_done_i`.** Here a design that never cleared the window would halt by mistake.
- **Sticky halt and ignored pins.** The bench checks that halt stays asserted until reset, that pin glitches without a termination give no result, and that a pin change only one edge old is not seen at termination. Each of these would show up as a spurious or missing pulse in the scoreboard.

// File: rtl/bus_exc_pkg.sv
package bus_exc_pkg;

    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_RETRY_WAIT = 2'd1,
        ST_SUSPEND    = 2'd2,
        ST_HALTED     = 2'd3
    } bus_state_t;

    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_DONE    = 3'd1,
        K_ERROR   = 3'd2,
        K_RETRY   = 3'd3,
        K_SUSPEND = 3'd4
    } term_kind_t;

    localparam int RES_W = 4;
    localparam int RES_DONE    = 0;
    localparam int RES_ERROR   = 1;
    localparam int RES_RETRY   = 2;
    localparam int RES_SUSPEND = 3;

endpackage

// File: rtl/bus_exc_sync.sv
module bus_exc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_n_i,
    output logic [WIDTH-1:0] pin_n_o
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], pin_n_i[b]};
            end
        end
        assign pin_n_o[b] = chain[LAST];
    end

endmodule

// File: rtl/bus_exc_classify.sv
module bus_exc_classify
    import bus_exc_pkg::*;
(
    input  logic       term_i,
    input  logic       berr_a_i,
    input  logic       halt_a_i,
    output term_kind_t kind_o
);
    always_comb begin
        kind_o = K_NONE;
        if (term_i) begin
            unique case ({berr_a_i, halt_a_i})
                2'b00: kind_o = K_DONE;
                2'b10: kind_o = K_ERROR;
                2'b11: kind_o = K_RETRY;
                2'b01: kind_o = K_SUSPEND;
                default: kind_o = K_NONE;
            endcase
        end
    end

    always_comb begin
        if (!term_i) begin
            a_r8_quiet_without_term: assert (kind_o == K_NONE);
        end
    end

endmodule

// File: rtl/bus_exc_tracker.sv
module bus_exc_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic err_evt_i,
    input  logic exc_done_i,
    output logic exc_act_o
);
    logic exc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exc_q <= 1'b1;
        end else if (err_evt_i) begin
            exc_q <= 1'b1;
        end else if (exc_done_i) begin
            exc_q <= 1'b0;
        end
    end

    assign exc_act_o = exc_q;

    a_r3_error_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt_i |=> exc_q);

    a_r10_done_closes_window: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_done_i && !err_evt_i) |=> !exc_q);

endmodule

// File: rtl/bus_exc_decoder.sv
module bus_exc_decoder
    import bus_exc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic term_i,
    input  logic berr_n_i,
    input  logic halt_n_i,
    input  logic exc_done_i,
    output logic res_done_o,
    output logic res_error_o,
    output logic res_retry_o,
    output logic res_suspend_o,
    output logic hold_o,
    output logic halted_o,
    output logic halt_drive_o
);
    localparam int PINS = 2;

    logic [PINS-1:0] pins_n_s;
    logic            berr_a;
    logic            halt_a;
    term_kind_t      kind;
    bus_state_t      state_q, state_d;
    logic [RES_W-1:0] res_q, res_d;
    logic            exc_act;
    logic            err_evt;
    logic            run_term;

    bus_exc_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n_i ({halt_n_i, berr_n_i}),
        .pin_n_o (pins_n_s)
    );

    assign berr_a = ~pins_n_s[0];
    assign halt_a = ~pins_n_s[1];

    bus_exc_classify u_classify (
        .term_i   (term_i),
        .berr_a_i (berr_a),
        .halt_a_i (halt_a),
        .kind_o   (kind)
    );

    assign run_term = (state_q == ST_RUN) && (kind != K_NONE);
    assign err_evt  = run_term && (kind == K_ERROR) && !exc_act;

    bus_exc_tracker u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_evt_i  (err_evt),
        .exc_done_i (exc_done_i),
        .exc_act_o  (exc_act)
    );

    // next state and result selection
    always_comb begin
        state_d = state_q;
        res_d   = '0;
        unique case (state_q)
            ST_RUN: begin
                if (run_term) begin
                    unique case (kind)
                        K_DONE: res_d[RES_DONE] = 1'b1;
                        K_RETRY: begin
                            res_d[RES_RETRY] = 1'b1;
                            state_d = ST_RETRY_WAIT;
                        end
                        K_SUSPEND: begin
                            res_d[RES_SUSPEND] = 1'b1;
                            state_d = ST_SUSPEND;
                        end
                        K_ERROR: begin
                            if (exc_act) begin
                                state_d = ST_HALTED;
                            end else begin
                                res_d[RES_ERROR] = 1'b1;
                            end
                        end
                        default: res_d = '0;
                    endcase
                end
            end
            ST_RETRY_WAIT: begin
                if (!berr_a && !halt_a) state_d = ST_RUN;
            end
            ST_SUSPEND: begin
                if (!halt_a) state_d = ST_RUN;
            end
            ST_HALTED: begin
                state_d = ST_HALTED;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            res_q   <= '0;
        end else begin
            state_q <= state_d;
            res_q   <= res_d;
        end
    end

    // outputs
    always_comb begin
        res_done_o    = res_q[RES_DONE];
        res_error_o   = res_q[RES_ERROR];
        res_retry_o   = res_q[RES_RETRY];
        res_suspend_o = res_q[RES_SUSPEND];
        hold_o        = (state_q != ST_RUN);
        halted_o      = (state_q == ST_HALTED);
        halt_drive_o  = (state_q == ST_HALTED);
    end

    a_r8_results_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_q));

    a_r8_result_needs_term: assert property (@(posedge clk) disable iff (!rst_n)
        (|res_q) |-> $past(term_i));

    a_r4_retry_holds_bus: assert property (@(posedge clk) disable iff (!rst_n)
        res_retry_o |-> hold_o);

    a_r5_suspend_holds_bus: assert property (@(posedge clk) disable iff (!rst_n)
        res_suspend_o |-> hold_o);

    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> (halted_o && halt_drive_o && (res_q == '0)));

    a_r6_double_fault_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted_o) |-> $past(exc_act));

endmodule

// File: tb/bus_exc_decoder_bench.sv
module bus_exc_decoder_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic term = 1'b0;
    logic drv_berr_n = 1'b1;
    logic drv_halt_n = 1'b1;
    logic exc_done = 1'b0;
    logic res_done, res_error, res_retry, res_suspend;
    logic hold, halted, halt_drive;
    logic halt_wire;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // expected result codes: 1 done, 2 error, 3 retry, 4 suspend
    int exp_q[$];

    always #5 clk = ~clk;

    assign halt_wire = halt_drive ? 1'b0 : drv_halt_n;

    bus_exc_decoder u_bus_exc_decoder (
        .clk(clk), .rst_n(rst_n), .term_i(term),
        .berr_n_i(drv_berr_n), .halt_n_i(halt_wire), .exc_done_i(exc_done),
        .res_done_o(res_done), .res_error_o(res_error),
        .res_retry_o(res_retry), .res_suspend_o(res_suspend),
        .hold_o(hold), .halted_o(halted), .halt_drive_o(halt_drive)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pop expected result on every observed pulse (R8 one-hot too)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (res_done | res_error | res_retry | res_suspend)) begin
                int act;
                act = res_done    ? 1 :
                      res_error   ? 2 :
                      res_retry   ? 3 : 4;
                check("R8 onehot", int'(res_done) + int'(res_error)
                      + int'(res_retry) + int'(res_suspend), 1);
                if (exp_q.size() == 0) begin
                    check("R8 unexpected pulse", act, 0);
                end else begin
                    check("R2-R5 result", act, exp_q.pop_front());
                end
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // pins change, then after sync delay a one-cycle termination
    task automatic bus_cycle(input logic b_n, input logic h_n, input int exp, input bit rel);
        drv_berr_n = b_n;
        drv_halt_n = h_n;
        settle(3);
        if (exp != 0) exp_q.push_back(exp);
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        if (rel) begin
            drv_berr_n = 1'b1;
            drv_halt_n = 1'b1;
            settle(4);
        end
    endtask

    task automatic pulse_exc_done();
        exc_done = 1'b1;
        @(negedge clk);
        exc_done = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drv_berr_n = 1'b1;
        drv_halt_n = 1'b1;
        settle(2);
        rst_n = 1'b1;
        settle(2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 hold", int'(hold), 0);
        check("R1 halted", int'(halted), 0);
        check("R1 drive", int'(halt_drive), 0);
        check("R1 results", int'(res_done | res_error | res_retry | res_suspend), 0);

        pulse_exc_done();                  // R10 close reset window
        bus_cycle(1'b1, 1'b1, 1, 1'b1);    // R2 done

        // R5 suspend and release
        bus_cycle(1'b1, 1'b0, 4, 1'b0);
        settle(3);
        check("R5 hold while halt", int'(hold), 1);
        drv_halt_n = 1'b1;
        settle(4);
        check("R5 hold released", int'(hold), 0);

        // R4 retry, hold until both released
        bus_cycle(1'b0, 1'b0, 3, 1'b0);
        settle(3);
        check("R4 hold both low", int'(hold), 1);
        drv_halt_n = 1'b1;
        settle(4);
        check("R4 hold berr still low", int'(hold), 1);
        drv_berr_n = 1'b1;
        settle(4);
        check("R4 hold released", int'(hold), 0);

        // R8 glitch without termination: no pulse, no state change
        drv_berr_n = 1'b0;
        drv_halt_n = 1'b0;
        settle(5);
        drv_berr_n = 1'b1;
        drv_halt_n = 1'b1;
        settle(4);
        check("R8 hold after glitch", int'(hold), 0);
        bus_cycle(1'b1, 1'b1, 1, 1'b1);    // R8 still normal

        // R9 change one edge before termination is not seen
        drv_berr_n = 1'b0;
        exp_q.push_back(1);
        term = 1'b1;
        @(negedge clk);
        term = 1'b0;
        drv_berr_n = 1'b1;
        settle(4);
        check("R9 no error seen", int'(halted), 0);

        // R3 error, then R6 double fault in its window
        bus_cycle(1'b0, 1'b1, 2, 1'b1);
        bus_cycle(1'b0, 1'b1, 0, 1'b1);
        check("R6 halted", int'(halted), 1);
        check("R6 drive", int'(halt_drive), 1);
        check("R6 hold", int'(hold), 1);
        check("R6 wire low", int'(halt_wire), 0);

        // R7 stays halted, terminations ignored
        bus_cycle(1'b1, 1'b1, 0, 1'b1);
        pulse_exc_done();
        bus_cycle(1'b1, 1'b1, 0, 1'b1);
        settle(3);
        check("R7 still halted", int'(halted), 1);
        check("R7 still driving", int'(halt_drive), 1);

        // R1 again after reset, then R6 in reset window
        do_reset();
        check("R1 halted cleared", int'(halted), 0);
        check("R1 drive cleared", int'(halt_drive), 0);
        bus_cycle(1'b0, 1'b1, 0, 1'b1);
        check("R6 reset window fault", int'(halted), 1);

        // R10 window closed by exc_done: two ordinary errors
        do_reset();
        pulse_exc_done();
        bus_cycle(1'b0, 1'b1, 2, 1'b1);
        pulse_exc_done();
        bus_cycle(1'b0, 1'b1, 2, 1'b1);
        check("R10 not halted", int'(halted), 0);

        settle(3);
        check("R2-R8 queue drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule